// File: doc/BRIEF.md
# Fractional-N Feedback Divider with Reference and LO Dividers

This block holds the digital dividers of a frequency synthesizer. The feedback path divides the VCO clock by a ratio built from a 7-bit integer and a 20-bit fraction. The fraction is realised by a first-order accumulator that stretches one output period in every overflow by a single VCO cycle. A mode input turns the fraction off, which gives plain integer division. On the reference side, the block produces a comparison strobe at the reference rate or at half of it. It also produces a reference clock for downstream logic, either passed through or halved.

The VCO domain also produces a second-LO clock at one quarter or one eighth of the VCO rate. A three-bit test selector routes either the feedback strobe or the reference strobe to one observation output. A shutdown input clears every divider and holds every output low. Each clock domain has its own reset synchroniser. The ratio fields come from a register bank and may change at any time. The feedback divider samples them only at the boundary between two output periods.

Top module: `fracn_clkgen`

## Requirements
- R1: With `frac_en` = 0 the feedback strobe has a period of exactly `n_int` VCO cycles. An `n_int` of 0 is treated as 1, so the strobe stays high on every cycle.
- R2: With `frac_en` = 1, the accumulator starts from zero. Over M output periods the total is then M*N + floor(M*F/2^20) VCO cycles, and every single period lasts N or N+1 cycles.
- R3: `f_frac` is the fraction times 2^20. For example, N = 0x56 with F = 0xE9069 gives 64 periods totalling 64*86 + 58 VCO cycles.
- R4: A new `n_int`, `f_frac` or `frac_en` value written during an output period does not change that period. The value takes effect from the next period.
- R5: With `ref_div2` = 0 the reference strobe is high on every reference cycle. With `ref_div2` = 1 it is high on alternate reference cycles, one cycle wide.
- R6: With `refout_div2` = 0, `ref_out` follows `ref_clk`. With `refout_div2` = 1, `ref_out` is a square wave at half the reference rate.
- R7: `lo2_clk` is a 50 % duty clock at VCO/4 when `lo_div8` = 0 and at VCO/8 when `lo_div8` = 1. A change of the select is applied only at the 8-cycle wrap, so it produces no pulse shorter than two cycles.
- R8: `test_sel` = 1 routes the feedback strobe to `test_out` and `test_sel` = 2 routes the reference strobe. `test_sel` = 0 and the values 3 to 7 hold `test_out` low.
- R9: While `shutdown` is high, all outputs are low. After release the dividers restart from a cleared state, and the first feedback strobe is seen one VCO cycle after release.
- R10: While `rst_n` is low, all outputs are low, including `ref_out` in pass-through mode.
- R11: For any ratio of 2 or more, the feedback strobe is exactly one VCO cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vco_clk | input | 1 | VCO clock, clocks the feedback and LO dividers |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Clears all dividers, forces outputs low |
| frac_en | input | 1 | 1 = fractional division, 0 = integer only |
| n_int | input | 7 | Integer part of the feedback ratio |
| f_frac | input | 20 | Fraction of the feedback ratio times 2^20 |
| ref_div2 | input | 1 | Reference strobe divide by 1 (0) or 2 (1) |
| refout_div2 | input | 1 | Reference output divide by 1 (0) or 2 (1) |
| lo_div8 | input | 1 | Second-LO divide by 4 (0) or 8 (1) |
| test_sel | input | 3 | Observation selector |
| fb_pulse | output | 1 | Divided feedback strobe, one VCO cycle wide |
| ref_pulse | output | 1 | Divided reference strobe |
| ref_out | output | 1 | Buffered or halved reference clock |
| lo2_clk | output | 1 | Second-LO clock |
| test_out | output | 1 | Observation output |

## Verification
The bench sums many consecutive feedback periods and compares the total with the closed-form carry count. A design that added the fraction on the wrong period, or dropped the carry, would be off by whole cycles, even if each single period looked plausible. A ratio written mid-period has to leave the running period intact. A divider that reloaded immediately would show a shortened period or a runt pulse. Ratio 0 and ratio 2 probe the counter wrap, and the release from shutdown must yield a strobe exactly one cycle later. The bench also confirms that unused test-selector codes keep the observation pin quiet while both strobes are active.

// File: rtl/fracn_pkg.sv
package fracn_pkg;
  localparam int unsigned TSEL_W   = 3;
  localparam logic [TSEL_W-1:0] TSEL_OFF = 3'd0;
  localparam logic [TSEL_W-1:0] TSEL_FB  = 3'd1;
  localparam logic [TSEL_W-1:0] TSEL_REF = 3'd2;
endpackage

// File: rtl/fracn_rst_sync.sv
module fracn_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/fracn_fbdiv.sv
module fracn_fbdiv #(
  parameter int unsigned N_W = 7,
  parameter int unsigned F_W = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           frac_en,
  input  logic [N_W-1:0] n_int,
  input  logic [F_W-1:0] f_frac,
  output logic           pulse
);
  localparam int unsigned CNT_W = N_W + 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [F_W-1:0]   acc_q, acc_d;
  logic             pulse_q, pulse_d;
  logic             boundary;
  logic [N_W-1:0]   n_eff;
  logic [F_W:0]     sum;
  logic             carry;

  always_comb begin
    boundary = (cnt_q == '0);
    n_eff    = (n_int == '0) ? N_W'(1) : n_int;
    sum      = {1'b0, acc_q} + {1'b0, (frac_en ? f_frac : {F_W{1'b0}})};
    carry    = sum[F_W];
    cnt_d    = cnt_q - CNT_ONE;
    acc_d    = acc_q;
    pulse_d  = boundary;
    if (boundary) begin
      cnt_d = {1'b0, n_eff} + CNT_W'(carry) - CNT_ONE;
      acc_d = frac_en ? sum[F_W-1:0] : '0;
    end
    if (clr) begin
      cnt_d   = '0;
      acc_d   = '0;
      pulse_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      acc_q   <= acc_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
endmodule

// File: rtl/fracn_refdiv.sv
module fracn_refdiv (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic div2,
  output logic pulse,
  output logic half
);
  logic tog_q, tog_d;
  logic pulse_q, pulse_d;

  always_comb begin
    tog_d   = ~tog_q;
    pulse_d = div2 ? ~tog_q : 1'b1;
    if (clr) begin
      tog_d   = 1'b0;
      pulse_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      tog_q   <= tog_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
  assign half  = tog_q;
endmodule

// File: rtl/fracn_lodiv.sv
module fracn_lodiv #(
  parameter int unsigned CW = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic div_long,
  output logic lo
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sel_q, sel_d;
  logic          lo_q, lo_d;

  always_comb begin
    cnt_d = cnt_q + CW'(1);
    sel_d = (&cnt_q) ? div_long : sel_q;
    lo_d  = sel_d ? cnt_d[CW-1] : cnt_d[CW-2];
    if (clr) begin
      cnt_d = '0;
      sel_d = 1'b0;
      lo_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      lo_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
      lo_q  <= lo_d;
    end
  end

  assign lo = lo_q;
endmodule

// File: rtl/fracn_clkgen.sv
module fracn_clkgen #(
  parameter int unsigned N_W  = 7,
  parameter int unsigned F_W  = 20,
  parameter int unsigned LO_CW = 3
) (
  input  logic                        vco_clk,
  input  logic                        ref_clk,
  input  logic                        rst_n,
  input  logic                        shutdown,
  input  logic                        frac_en,
  input  logic [N_W-1:0]              n_int,
  input  logic [F_W-1:0]              f_frac,
  input  logic                        ref_div2,
  input  logic                        refout_div2,
  input  logic                        lo_div8,
  input  logic [fracn_pkg::TSEL_W-1:0] test_sel,
  output logic                        fb_pulse,
  output logic                        ref_pulse,
  output logic                        ref_out,
  output logic                        lo2_clk,
  output logic                        test_out
);
  logic vco_rst_n, ref_rst_n;
  logic fb_raw, ref_raw, ref_half, lo_raw;
  logic run;

  fracn_rst_sync u_vco_rst (.clk(vco_clk), .arst_n(rst_n), .srst_n(vco_rst_n));
  fracn_rst_sync u_ref_rst (.clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));

  fracn_fbdiv #(.N_W(N_W), .F_W(F_W)) u_fbdiv (
    .clk(vco_clk), .rst_n(vco_rst_n), .clr(shutdown),
    .frac_en(frac_en), .n_int(n_int), .f_frac(f_frac), .pulse(fb_raw)
  );

  fracn_lodiv #(.CW(LO_CW)) u_lodiv (
    .clk(vco_clk), .rst_n(vco_rst_n), .clr(shutdown),
    .div_long(lo_div8), .lo(lo_raw)
  );

  fracn_refdiv u_refdiv (
    .clk(ref_clk), .rst_n(ref_rst_n), .clr(shutdown),
    .div2(ref_div2), .pulse(ref_raw), .half(ref_half)
  );

  assign run       = ~shutdown;
  assign fb_pulse  = fb_raw & run;
  assign lo2_clk   = lo_raw & run;
  assign ref_pulse = ref_raw & run;
  assign ref_out   = (refout_div2 ? ref_half : (ref_clk & ref_rst_n)) & run;

  always_comb begin
    case (test_sel)
      fracn_pkg::TSEL_FB:  test_out = fb_pulse;
      fracn_pkg::TSEL_REF: test_out = ref_pulse;
      default:             test_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/fracn_clkgen_chk.sv
module fracn_clkgen_chk #(
  parameter int unsigned N_W = 7
) (
  input logic           vco_clk,
  input logic           ref_clk,
  input logic           rst_n,
  input logic           shutdown,
  input logic [N_W-1:0] n_int,
  input logic           ref_div2,
  input logic           fb_pulse,
  input logic           ref_pulse,
  input logic           ref_out,
  input logic           lo2_clk,
  input logic           test_out
);
  AST_FB_MIN_GAP: assert property (@(posedge vco_clk) disable iff (!rst_n)
    (fb_pulse && ($past(n_int) > N_W'(1))) |=> !fb_pulse); // R11

  AST_SHDN_VCO_QUIET: assert property (@(posedge vco_clk) disable iff (!rst_n)
    shutdown |-> (!fb_pulse && !lo2_clk && !test_out)); // R9

  AST_SHDN_REF_QUIET: assert property (@(posedge ref_clk) disable iff (!rst_n)
    shutdown |-> (!ref_pulse && !ref_out)); // R9

  AST_REF_HALF_RATE: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_div2 && $past(ref_div2) && ref_pulse && !shutdown) |=> !ref_pulse); // R5

  AST_LO_HIGH_PAIR: assert property (@(posedge vco_clk) disable iff (!rst_n)
    ($rose(lo2_clk) && !shutdown) |=> (lo2_clk || shutdown)); // R7
endmodule

bind fracn_clkgen fracn_clkgen_chk #(.N_W(N_W)) u_chk (
  .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .shutdown(shutdown),
  .n_int(n_int), .ref_div2(ref_div2), .fb_pulse(fb_pulse),
  .ref_pulse(ref_pulse), .ref_out(ref_out), .lo2_clk(lo2_clk),
  .test_out(test_out)
);

// File: tb/fracn_clkgen_bench.sv
module fracn_clkgen_bench;
  logic vco_clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst_n, shutdown, frac_en, ref_div2, refout_div2, lo_div8;
  logic [6:0]  n_int;
  logic [19:0] f_frac;
  logic [2:0]  test_sel;
  logic fb_pulse, ref_pulse, ref_out, lo2_clk, test_out;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 ref_clk = ~ref_clk;   // 50 MHz
  always #2  vco_clk = ~vco_clk;

  fracn_clkgen u_fracn_clkgen (
    .vco_clk(vco_clk), .ref_clk(ref_clk), .rst_n(rst_n), .shutdown(shutdown),
    .frac_en(frac_en), .n_int(n_int), .f_frac(f_frac), .ref_div2(ref_div2),
    .refout_div2(refout_div2), .lo_div8(lo_div8), .test_sel(test_sel),
    .fb_pulse(fb_pulse), .ref_pulse(ref_pulse), .ref_out(ref_out),
    .lo2_clk(lo2_clk), .test_out(test_out)
  );

  // {frac_en, N, F, periods}
  localparam int NV = 7;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 7'd10,  20'h00000, 20'd8},
    {1'b0, 7'd2,   20'h00000, 20'd16},
    {1'b0, 7'd127, 20'h00000, 20'd4},
    {1'b1, 7'h56,  20'hE9069, 20'd64},
    {1'b1, 7'd5,   20'h80000, 20'd16},
    {1'b1, 7'd3,   20'hFFFFF, 20'd32},
    {1'b1, 7'd2,   20'h00001, 20'd8}
  };

  function automatic longint exp_total(bit fe, int n, int f, int m);
    longint t = longint'(m) * n;
    if (fe) t += (longint'(m) * f) >> 20;
    return t;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic next_period(output int p);
    p = 0;
    do begin
      @(negedge vco_clk);
      p++;
    end while (!fb_pulse && p < 4000);
  endtask

  task automatic report;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      report();
      $finish;
    end
  end

  initial begin
    int p, tot, bad, hi, rises, mism, prev;
    longint lo_n;
    rst_n = 1'b0; shutdown = 1'b0; frac_en = 1'b0; n_int = 7'd4; f_frac = '0;
    ref_div2 = 1'b0; refout_div2 = 1'b0; lo_div8 = 1'b0; test_sel = 3'd1;

    // R10: outputs low in reset, even ref_out in pass-through mode
    @(posedge ref_clk); #5;
    chk("R10", "ref_out in reset", ref_out, 0);
    chk("R10", "ref_pulse in reset", ref_pulse, 0);
    @(negedge vco_clk);
    chk("R10", "fb/lo/test in reset", {fb_pulse, lo2_clk, test_out}, 0);
    repeat (5) @(negedge vco_clk);
    rst_n = 1'b1;
    repeat (10) @(negedge vco_clk);

    // Vector table: R1 / R2 / R3 / R11
    for (int v = 0; v < NV; v++) begin
      bit fe; int n, f, m;
      fe = VEC[v][47]; n = int'(VEC[v][46:40]); f = int'(VEC[v][39:20]); m = int'(VEC[v][19:0]);
      frac_en = 1'b0; n_int = 7'(n); f_frac = 20'(f);
      next_period(p);
      next_period(p);
      frac_en = fe;
      next_period(p);
      tot = 0; bad = 0;
      for (int k = 0; k < m; k++) begin
        next_period(p);
        tot += p;
        if (!(p == n || (fe && p == n + 1))) bad++;
      end
      lo_n = exp_total(fe, n, f, m);
      chk(fe ? ((n == 'h56) ? "R3" : "R2") : "R1", $sformatf("vector %0d total cycles", v), tot, lo_n);
      chk(fe ? "R2" : "R11", $sformatf("vector %0d periods out of range", v), bad, 0);
    end

    // R1: ratio 0 treated as 1, strobe high every cycle
    frac_en = 1'b0; n_int = 7'd0;
    repeat (300) @(negedge vco_clk);
    hi = 0;
    for (int k = 0; k < 8; k++) begin @(negedge vco_clk); if (fb_pulse) hi++; end
    chk("R1", "ratio 0 high samples", hi, 8);

    // R4: change of N mid-period leaves the running period intact
    n_int = 7'd10;
    next_period(p);
    next_period(p);
    repeat (3) @(negedge vco_clk);
    n_int = 7'd4;
    next_period(p);
    chk("R4", "period in flight", p + 3, 10);
    next_period(p);
    chk("R4", "period after change", p, 4);

    // R5: reference strobe
    ref_div2 = 1'b0;
    repeat (3) @(negedge ref_clk);
    hi = 0;
    for (int k = 0; k < 8; k++) begin @(negedge ref_clk); if (ref_pulse) hi++; end
    chk("R5", "div1 high count", hi, 8);
    ref_div2 = 1'b1;
    repeat (3) @(negedge ref_clk);
    hi = 0; mism = 0; prev = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge ref_clk);
      if (ref_pulse) hi++;
      if (ref_pulse && prev == 1) mism++;
      prev = int'(ref_pulse);
    end
    chk("R5", "div2 high count", hi, 4);
    chk("R5", "div2 back-to-back highs", mism, 0);

    // R6: reference output
    refout_div2 = 1'b0;
    mism = 0;
    for (int k = 0; k < 4; k++) begin
      @(posedge ref_clk); #5; if (ref_out !== 1'b1) mism++;
      @(negedge ref_clk); #5; if (ref_out !== 1'b0) mism++;
    end
    chk("R6", "pass-through mismatches", mism, 0);
    refout_div2 = 1'b1;
    repeat (2) @(posedge ref_clk);
    rises = 0; prev = -1;
    for (int k = 0; k < 8; k++) begin
      @(posedge ref_clk); #5;
      if (prev >= 0 && int'(ref_out) != prev) rises++;
      prev = int'(ref_out);
    end
    chk("R6", "halved output transitions", rises, 7);

    // R7: second-LO divider
    for (int s = 0; s < 2; s++) begin
      lo_div8 = s[0];
      repeat (20) @(negedge vco_clk);
      hi = 0; rises = 0; prev = int'(lo2_clk);
      for (int k = 0; k < 32; k++) begin
        @(negedge vco_clk);
        if (lo2_clk) hi++;
        if (lo2_clk && prev == 0) rises++;
        prev = int'(lo2_clk);
      end
      chk("R7", $sformatf("lo sel=%0d high samples", s), hi, 16);
      chk("R7", $sformatf("lo sel=%0d rising edges", s), rises, s ? 4 : 8);
    end

    // R8: test selector
    n_int = 7'd5; test_sel = 3'd1;
    repeat (12) @(negedge vco_clk);
    mism = 0; hi = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge vco_clk);
      if (test_out !== fb_pulse) mism++;
      if (fb_pulse) hi++;
    end
    chk("R8", "sel 1 mismatches", mism, 0);
    chk("R8", "sel 1 strobes seen", hi, 8);
    test_sel = 3'd2;
    mism = 0;
    for (int k = 0; k < 8; k++) begin @(negedge ref_clk); if (test_out !== ref_pulse) mism++; end
    chk("R8", "sel 2 mismatches", mism, 0);
    n_int = 7'd0; ref_div2 = 1'b0;
    for (int s = 0; s < 8; s++) begin
      if (s == 1 || s == 2) continue;
      test_sel = 3'(s);
      hi = 0;
      for (int k = 0; k < 20; k++) begin @(negedge vco_clk); if (test_out) hi++; end
      chk("R8", $sformatf("sel %0d test_out highs", s), hi, 0);
    end

    // R9: shutdown
    test_sel = 3'd1; n_int = 7'd6; refout_div2 = 1'b0;
    repeat (20) @(negedge vco_clk);
    shutdown = 1'b1;
    repeat (2) @(negedge vco_clk);
    chk("R9", "vco outputs in shutdown", {fb_pulse, lo2_clk, test_out}, 0);
    @(posedge ref_clk); #5;
    chk("R9", "ref outputs in shutdown", {ref_out, ref_pulse}, 0);
    repeat (5) @(negedge vco_clk);
    shutdown = 1'b0;
    @(negedge vco_clk);
    chk("R9", "strobe one cycle after release", fb_pulse, 1);
    next_period(p);
    chk("R9", "first period after release", p, 6);

    done = 1'b1;
    report();
    $finish;
  end
endmodule